// File: doc/BRIEF.md
# Serial Command and Result Port for a Multichannel SAR Converter

This block is the digital serial port of a multichannel successive-approximation converter. It is used in external-clock mode. A host acts as an SPI controller with CPOL=0 and CPHA=0. It lowers chip-select, shifts an 8-bit command into DIN on SCLK rising edges, and reads the result back on DOUT. DOUT changes on SCLK falling edges. The port tells the analog side which channel to route and when to take the sample. It then captures the parallel conversion value and serializes it as fourteen data bits, MSB first, followed by two status bits.

The SCLK, chip-select and DIN pins are resynchronized into a faster system clock. Edges are found by comparing each synchronized sample with the one before it. A static width select picks between two framings. In the narrow framing the transaction lasts 24 SCLK cycles. In the wide framing it lasts 32, and the acquisition window is eight SCLK cycles longer. Raising chip-select always ends the transaction. It puts the block into the shutdown mode held in the command register, and any conversion still running is discarded.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the port reports shutdown (`pwr_down`=1) with `pwr_mode`=2'b11, `chan_sel`=0 and `dout_oe`=0. These values come from the command register's power-up value 8'b0000_0110.
- R2: While chip-select is low, DIN is taken MSB first on each of the first 8 SCLK rising edges. The command is complete at the 8th rising edge. Bits 7:5 of the command are the channel, bits 2:1 the shutdown mode, and bits 4:3 and 0 have no effect. DIN is ignored from the 9th rising edge onward.
- R3: `chan_sel` takes command bits 7:5 at the 3rd SCLK rising edge and stays unchanged for the rest of the transaction.
- R4: `sample_stb` is a single one-system-clock pulse per transaction. It comes at the 6th SCLK falling edge when `wide_mode`=0 and at the 14th when `wide_mode`=1.
- R5: `conv_data` is captured one system clock after `sample_stb`. Later changes to `conv_data` do not alter the word shifted out.
- R6: The 16-bit output word is conv_data[13:0] followed by two status bits, both 0. Its first bit appears at the 8th SCLK falling edge (narrow) or the 16th (wide), and each later falling edge presents the next bit.
- R7: While chip-select is low, `dout` is 0 before the word starts. Every SCLK falling edge after the 16th word bit shifts out 0.
- R8: `dout_oe` is 0 while chip-select is high and 1 while it is low.
- R9: A chip-select rise sets `pwr_down`=1 and loads `pwr_mode` with the register's bits 2:1. A transaction cut short before its 8th rising edge leaves the register unchanged. A chip-select rise seen in the same system clock as the sampling falling edge suppresses `sample_stb`.
- R10: After an aborted transaction, the next transaction counts SCLK edges from one again and behaves as a fresh transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data |
| wide_mode | input | 1 | Static framing select: 0 narrow (24 clocks), 1 wide (32 clocks) |
| conv_data | input | DATA_W | Parallel conversion value from the converter core |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for the DOUT pad driver |
| sample_stb | output | 1 | One-clock pulse marking the sample instant |
| chan_sel | output | 3 | Selected input channel |
| pwr_down | output | 1 | Block is in shutdown |
| pwr_mode | output | 2 | Shutdown mode in force |

## Verification
The main collision is a chip-select rise that reaches the synchronizer in the same system clock as the sampling SCLK falling edge. In that cycle abort and sample compete. The bench provokes it by driving SCLK low and chip-select high in the same instant, at the 6th falling edge in narrow framing and at the 14th in wide framing. The run passes only if no strobe is recorded, `pwr_mode` reflects a register that is committed only when 8 rising edges have occurred, and the following transaction counts from edge one with a correct result.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int DATA_W = 14,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              wide_mode,
  input  logic [DATA_W-1:0] conv_data,
  output logic              dout,
  output logic              dout_oe,
  output logic              sample_stb,
  output logic [2:0]        chan_sel,
  output logic              pwr_down,
  output logic [1:0]        pwr_mode
);
  localparam int WORD_W = DATA_W + 2;
  localparam int CMD_W  = 8;

  logic [2:0]        cs_sr, sclk_sr;
  logic [1:0]        din_sr;
  logic [CNT_W-1:0]  rise_cnt, fall_cnt;
  logic [1:0]        shreg;
  logic [1:0]        pwr_sel;
  logic [WORD_W-1:0] obuf;
  logic              started;

  wire cs_q  = cs_sr[1];
  wire cs_up = cs_sr[1] & ~cs_sr[2];
  wire cs_dn = ~cs_sr[1] & cs_sr[2];
  wire rise  = ~cs_q & sclk_sr[1] & ~sclk_sr[2];
  wire fall  = ~cs_q & ~sclk_sr[1] & sclk_sr[2];
  wire [CNT_W-1:0] smp_at = wide_mode ? CNT_W'(6 + CMD_W) : CNT_W'(6);
  wire [CNT_W-1:0] out_at = wide_mode ? CNT_W'(2 * CMD_W) : CNT_W'(CMD_W);

  assign dout    = started & obuf[WORD_W-1];
  assign dout_oe = ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr      <= '1;
      sclk_sr    <= '0;
      din_sr     <= '0;
      rise_cnt   <= '0;
      fall_cnt   <= '0;
      shreg      <= '0;
      chan_sel   <= '0;
      pwr_sel    <= 2'b11;
      pwr_mode   <= 2'b11;
      pwr_down   <= 1'b1;
      sample_stb <= 1'b0;
      obuf       <= '0;
      started    <= 1'b0;
    end else begin
      cs_sr      <= {cs_sr[1:0], cs_n};
      sclk_sr    <= {sclk_sr[1:0], sclk};
      din_sr     <= {din_sr[0], din};
      sample_stb <= 1'b0;
      if (cs_q) begin
        rise_cnt <= '0;
        fall_cnt <= '0;
        started  <= 1'b0;
        if (cs_up) begin
          pwr_down <= 1'b1;
          pwr_mode <= pwr_sel;
        end
      end else begin
        if (cs_dn) pwr_down <= 1'b0;
        if (rise) begin
          if (rise_cnt != '1) rise_cnt <= rise_cnt + 1'b1;
          if (rise_cnt < CNT_W'(CMD_W)) shreg <= {shreg[0], din_sr[1]};
          if (rise_cnt == CNT_W'(2)) chan_sel <= {shreg, din_sr[1]};
          if (rise_cnt == CNT_W'(CMD_W - 1)) pwr_sel <= shreg;
        end
        if (fall) begin
          if (fall_cnt != '1) fall_cnt <= fall_cnt + 1'b1;
          if (fall_cnt == smp_at - 1'b1) sample_stb <= 1'b1;
          if (fall_cnt == out_at - 1'b1) started <= 1'b1;
          else if (started) obuf <= {obuf[WORD_W-2:0], 1'b0};
        end
        if (sample_stb) obuf <= {conv_data, 2'b00};
      end
    end
  end

  AST_SHUTDOWN_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |=> (pwr_down && !dout_oe)); // R9

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb); // R4

  AST_STB_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !pwr_down); // R10

  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_q && rise_cnt > CNT_W'(3)) |-> $stable(chan_sel)); // R3

  AST_ZERO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_q && fall_cnt >= out_at + CNT_W'(WORD_W)) |-> !dout); // R7
endmodule

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0, wide_mode = 1'b0;
  logic [13:0] conv_data = '0;
  logic dout, dout_oe, sample_stb, pwr_down;
  logic [2:0] chan_sel;
  logic [1:0] pwr_mode;

  int n_chk = 0, n_fail = 0, stb_cnt = 0, stb_at = 0, cur_fall = 0;
  logic [7:0] exp_cmd = 8'h06;
  logic [2:0] exp_chan = 3'd0;
  bit after_abort = 0;

  always #4 clk = ~clk;

  adc_serial_port i_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .wide_mode(wide_mode), .conv_data(conv_data), .dout(dout), .dout_oe(dout_oe),
    .sample_stb(sample_stb), .chan_sel(chan_sel), .pwr_down(pwr_down), .pwr_mode(pwr_mode));

  always @(posedge clk) if (sample_stb) begin stb_cnt++; stb_at = cur_fall; end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] cmd, input bit wide, input logic [13:0] data,
                      input int nclk, input bit collide);
    int smp, outp;
    logic [15:0] word, rx;
    int nrx;
    smp = wide ? 14 : 6;
    outp = wide ? 16 : 8;
    word = {data, 2'b00};
    rx = '0; nrx = 0;
    wide_mode = wide; conv_data = data; stb_cnt = 0; cur_fall = 0;
    cs_n = 1'b0; hw(H);
    chk("R8 oe low cs", {31'd0, dout_oe}, 32'd1);
    chk("R7 idle dout", {31'd0, dout}, 32'd0);
    for (int i = 1; i <= nclk; i++) begin
      din = (i <= 8) ? cmd[8-i] : 1'($urandom);
      sclk = 1'b1; hw(H);
      if (i == 2) chk("R3 chan before 3rd", {29'd0, chan_sel}, {29'd0, exp_chan});
      if (i == 3) begin
        exp_chan = cmd[7:5];
        chk("R3 chan at 3rd", {29'd0, chan_sel}, {29'd0, exp_chan});
      end
      sclk = 1'b0; cur_fall = i;
      if (collide && i == nclk) cs_n = 1'b1;
      hw(H);
      if (i == smp) conv_data = 14'($urandom);
      if (!(collide && i == nclk)) begin
        if (i >= outp && i - outp < 16) begin
          chk("R6 word bit", {31'd0, dout}, {31'd0, word[15-(i-outp)]});
          rx = {rx[14:0], dout}; nrx++;
        end else begin
          chk("R7 zero bit", {31'd0, dout}, 32'd0);
        end
      end
    end
    if (nrx == 16) chk("R5 captured word", {16'd0, rx}, {16'd0, word});
    if (!collide) begin cs_n = 1'b1; hw(H); end
    if (nclk >= 8) exp_cmd = cmd;
    chk(nclk >= 8 ? "R2 mode from cmd" : "R9 mode kept", {30'd0, pwr_mode}, {30'd0, exp_cmd[2:1]});
    chk("R9 shutdown", {31'd0, pwr_down}, 32'd1);
    chk("R8 oe high cs", {31'd0, dout_oe}, 32'd0);
    if (nclk > smp || (nclk == smp && !collide)) begin
      chk(after_abort ? "R10 strobe count" : "R4 strobe count", stb_cnt, 1);
      chk(after_abort ? "R10 strobe edge" : "R4 strobe edge", stb_at, smp);
    end else begin
      chk("R9 strobe suppressed", stb_cnt, 0);
    end
    after_abort = collide || nclk < (wide ? 32 : 24);
    hw(H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    hw(5); rst_n = 1'b1; hw(4);
    chk("R1 oe", {31'd0, dout_oe}, 32'd0);
    chk("R1 pwr_down", {31'd0, pwr_down}, 32'd1);
    chk("R1 pwr_mode", {30'd0, pwr_mode}, 32'd3);
    chk("R1 chan", {29'd0, chan_sel}, 32'd0);
    chk("R1 no strobe", stb_cnt, 0);
    xfer(8'b1010_0010, 1'b0, 14'h2A5C, 24, 1'b0);
    xfer(8'b0111_1101, 1'b1, 14'h3FFF, 32, 1'b0);
    xfer(8'b0010_0000, 1'b0, 14'h0001, 30, 1'b0);
    xfer(8'b1100_0100, 1'b1, 14'h2000, 40, 1'b0);
    xfer(8'b0100_0110, 1'b0, 14'h1234, 12, 1'b0);
    xfer(8'b1110_0000, 1'b0, 14'h0F0F, 6, 1'b1);
    xfer(8'b0011_1011, 1'b0, 14'h3C3C, 24, 1'b0);
    xfer(8'b1000_0010, 1'b1, 14'h1555, 14, 1'b1);
    xfer(8'b0101_0100, 1'b1, 14'h2AAA, 32, 1'b0);
    for (int k = 0; k < 24; k++) begin
      bit w;
      w = 1'($urandom);
      xfer(8'($urandom), w, 14'($urandom), (w ? 32 : 24) + int'($urandom % 5), 1'b0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule